// File: doc/BRIEF.md
# Smart Card Contact Power Sequencer

This block sits between a host controller and the contacts of a smart card slot. The host supplies its own reset, clock, data and two auxiliary lines. Every one of these reaches the card only through a gate that the block opens and closes. The host starts a session by pulling either of two active-low supply commands low, one per supply voltage. The block then enables the card supply and holds every contact low until the supply reports valid. After that it raises a ready flag and lets each host line pass straight through to its contact.

A session ends when the host releases both supply commands. It also ends, without any host action, on overcurrent, undervoltage, card withdrawal or an off-acknowledge. A session that has not reached ready within a checkpoint window is ended the same way. Power-down always runs as four timed steps in one order. The reset contact is cut first, then the clock contact, then data together with both auxiliary contacts, and finally the supply enable. All intervals are counted in system clock cycles and set by parameters.

Top module: `cardPowerSeq`

## Requirements
- R1: Out of reset, and whenever the supply enable is low, the contact outputs cardRst, cardClk, cardIo, cardAux1 and cardAux2 are low, and ready is low.
- R2: In the idle state, a high-to-low transition on either cmdVccAN or cmdVccBN starts a session only if cardPresent=1 and offN=1. The session sets supplyEn high at the next clock edge. Without both conditions, supplyEn stays low.
- R3: From the start of a session until ready rises, every contact output stays low, whatever the host reset, clock, data and auxiliary inputs do.
- R4: When supplyGood=1 and no stop condition is present, ready rises one clock edge after supplyEn. From then on, each contact output equals its host input in the same cycle.
- R5: If ready has not risen within T_CHK cycles after supplyEn rises, power-down starts. A session that reaches ready before that point is not affected by the checkpoint.
- R6: During a session, each of the following lowers ready at the next clock edge and starts power-down: both commands high, overCurrent=1, underVoltage=1, cardPresent=0 or offAck=1.
- R7: Power-down is counted from the edge that lowers ready. cardRst goes low T_RST edges after that edge. cardClk goes low T_CLK edges later. cardIo, cardAux1 and cardAux2 go low T_IO edges after that. supplyEn goes low T_VCC edges after that.
- R8: At its step, the clock contact is forced low even while hostClk is high, so the last clock pulse can be cut short.
- R9: After power-down completes, command edges are ignored until both commands have been seen high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdVccAN | input | 1 | Supply command, first voltage, active low |
| cmdVccBN | input | 1 | Supply command, second voltage, active low |
| hostRst | input | 1 | Host reset line to card |
| hostClk | input | 1 | Host clock line to card |
| hostIo | input | 1 | Host data line to card |
| hostAux1 | input | 1 | Host first auxiliary line |
| hostAux2 | input | 1 | Host second auxiliary line |
| cardPresent | input | 1 | Card inserted in slot |
| offN | input | 1 | Must be high for a session to start |
| supplyGood | input | 1 | Card supply within range |
| overCurrent | input | 1 | Supply overcurrent fault |
| underVoltage | input | 1 | Supply undervoltage fault |
| offAck | input | 1 | Off acknowledge, forces power-down |
| cardRst | output | 1 | Gated reset contact |
| cardClk | output | 1 | Gated clock contact |
| cardIo | output | 1 | Gated data contact |
| cardAux1 | output | 1 | Gated first auxiliary contact |
| cardAux2 | output | 1 | Gated second auxiliary contact |
| supplyEn | output | 1 | Internal supply enable |
| ready | output | 1 | Session ready flag |

## Verification
The bench holds every host line high during each power-down. It then checks every contact on both sides of its step edge, so a swapped order or an off-by-one interval shows up as a contact dropping a cycle early or late. A clock step that waits for the host clock to fall would leave cardClk high past its step. A checkpoint that counts from the wrong edge, or that also fires after ready, would either miss the silent-supply session or kill the late-ready one. A rearm that does not require both commands high would power up again on a single falling command left over from a fault. A start path that skips the card-present or offN test would raise supplyEn on an empty slot.

// File: rtl/cardSeqPkg.sv
package cardSeqPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_LIVE,
    ST_DRST,
    ST_DCLK,
    ST_DIO,
    ST_DVCC,
    ST_REARM
  } seqState_e;

  // Strobes from control to the contact datapath
  typedef struct packed {
    logic vccOn;
    logic ioOn;
    logic clkOn;
    logic rstOn;
  } gateStrobe_t;

endpackage

// File: rtl/cardSeqCtrl.sv
module cardSeqCtrl
  import cardSeqPkg::*;
#(
  parameter int T_RST = 200,
  parameter int T_CLK = 200,
  parameter int T_IO  = 200,
  parameter int T_VCC = 200,
  parameter int T_CHK = 50000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdVccAN,
  input  logic        cmdVccBN,
  input  logic        cardPresent,
  input  logic        offN,
  input  logic        supplyGood,
  input  logic        overCurrent,
  input  logic        underVoltage,
  input  logic        offAck,
  output gateStrobe_t gate,
  output logic        ready
);

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAXT = maxOf(maxOf(maxOf(T_RST, T_CLK), maxOf(T_IO, T_VCC)), T_CHK);
  localparam int CW   = $clog2(MAXT + 1);

  seqState_e   state, stateNext;
  logic [CW-1:0] cnt, stepLimit;
  logic        cmdPrevA, cmdPrevB;
  logic        fallAny, bothHigh, fault, stopReq, startOk, cntDone;
  gateStrobe_t gateQ;

  assign fallAny  = (cmdPrevA & ~cmdVccAN) | (cmdPrevB & ~cmdVccBN);
  assign bothHigh = cmdVccAN & cmdVccBN;
  assign fault    = overCurrent | underVoltage | ~cardPresent | offAck;
  assign stopReq  = bothHigh | fault;
  assign startOk  = (state == ST_IDLE) & fallAny & cardPresent & offN;

  always_comb begin
    case (state)
      ST_WAIT: stepLimit = CW'(T_CHK);
      ST_DRST: stepLimit = CW'(T_RST);
      ST_DCLK: stepLimit = CW'(T_CLK);
      ST_DIO:  stepLimit = CW'(T_IO);
      ST_DVCC: stepLimit = CW'(T_VCC);
      default: stepLimit = CW'(1);
    endcase
  end

  assign cntDone = (cnt == stepLimit - CW'(1));

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:  if (startOk) stateNext = ST_WAIT;
      ST_WAIT: begin
        if (stopReq)         stateNext = ST_DRST;
        else if (supplyGood) stateNext = ST_LIVE;
        else if (cntDone)    stateNext = ST_DRST;
      end
      ST_LIVE:  if (stopReq) stateNext = ST_DRST;
      ST_DRST:  if (cntDone) stateNext = ST_DCLK;
      ST_DCLK:  if (cntDone) stateNext = ST_DIO;
      ST_DIO:   if (cntDone) stateNext = ST_DVCC;
      ST_DVCC:  if (cntDone) stateNext = ST_REARM;
      ST_REARM: if (bothHigh) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      cmdPrevA <= 1'b1;
      cmdPrevB <= 1'b1;
      gateQ    <= '0;
    end else begin
      state    <= stateNext;
      cnt      <= (stateNext != state) ? '0 : cnt + CW'(1);
      cmdPrevA <= cmdVccAN;
      cmdPrevB <= cmdVccBN;
      if (state == ST_IDLE && stateNext == ST_WAIT) gateQ.vccOn <= 1'b1;
      if (state == ST_WAIT && stateNext == ST_LIVE) begin
        gateQ.rstOn <= 1'b1;
        gateQ.clkOn <= 1'b1;
        gateQ.ioOn  <= 1'b1;
      end
      if (state == ST_DRST && stateNext == ST_DCLK)  gateQ.rstOn <= 1'b0;
      if (state == ST_DCLK && stateNext == ST_DIO)   gateQ.clkOn <= 1'b0;
      if (state == ST_DIO  && stateNext == ST_DVCC)  gateQ.ioOn  <= 1'b0;
      if (state == ST_DVCC && stateNext == ST_REARM) gateQ.vccOn <= 1'b0;
    end
  end

  assign gate  = gateQ;
  assign ready = (state == ST_LIVE);

  AST_GATE_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    !(gateQ.rstOn && !gateQ.clkOn) && !(gateQ.clkOn && !gateQ.ioOn) && !(gateQ.ioOn && !gateQ.vccOn)); // R7
  AST_READY_POWERED: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> gateQ.vccOn); // R4
  AST_STOP_DROPS_READY: assert property (@(posedge clk) disable iff (!rstN)
    (ready && stopReq) |=> !ready); // R6
  AST_ACCEPT_POWERS: assert property (@(posedge clk) disable iff (!rstN)
    startOk |=> gateQ.vccOn); // R2
  AST_NO_CARD_NO_POWER: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !(cardPresent && offN)) |=> !gateQ.vccOn); // R2
  AST_CHECKPOINT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && cntDone && !supplyGood) |=> (state == ST_DRST)); // R5
  AST_REARM_WAITS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REARM && !bothHigh) |=> !gateQ.vccOn); // R9

endmodule

// File: rtl/cardSeqPath.sv
module cardSeqPath
  import cardSeqPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  gateStrobe_t gate,
  input  logic        hostRst,
  input  logic        hostClk,
  input  logic        hostIo,
  input  logic        hostAux1,
  input  logic        hostAux2,
  output logic        cardRst,
  output logic        cardClk,
  output logic        cardIo,
  output logic        cardAux1,
  output logic        cardAux2,
  output logic        supplyEn
);

  // Straight AND gating: the clock is cut the instant its strobe drops
  assign cardRst  = hostRst  & gate.rstOn;
  assign cardClk  = hostClk  & gate.clkOn;
  assign cardIo   = hostIo   & gate.ioOn;
  assign cardAux1 = hostAux1 & gate.ioOn;
  assign cardAux2 = hostAux2 & gate.ioOn;
  assign supplyEn = gate.vccOn;

  AST_LINES_LOW_UNPOWERED: assert property (@(posedge clk) disable iff (!rstN)
    !gate.vccOn |-> !(cardRst | cardClk | cardIo | cardAux1 | cardAux2)); // R1

endmodule

// File: rtl/cardPowerSeq.sv
module cardPowerSeq
  import cardSeqPkg::*;
#(
  parameter int T_RST = 200,
  parameter int T_CLK = 200,
  parameter int T_IO  = 200,
  parameter int T_VCC = 200,
  parameter int T_CHK = 50000
) (
  input  logic clk,
  input  logic rstN,
  input  logic cmdVccAN,
  input  logic cmdVccBN,
  input  logic hostRst,
  input  logic hostClk,
  input  logic hostIo,
  input  logic hostAux1,
  input  logic hostAux2,
  input  logic cardPresent,
  input  logic offN,
  input  logic supplyGood,
  input  logic overCurrent,
  input  logic underVoltage,
  input  logic offAck,
  output logic cardRst,
  output logic cardClk,
  output logic cardIo,
  output logic cardAux1,
  output logic cardAux2,
  output logic supplyEn,
  output logic ready
);

  gateStrobe_t gate;

  cardSeqCtrl #(
    .T_RST(T_RST), .T_CLK(T_CLK), .T_IO(T_IO), .T_VCC(T_VCC), .T_CHK(T_CHK)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cmdVccAN(cmdVccAN), .cmdVccBN(cmdVccBN),
    .cardPresent(cardPresent), .offN(offN), .supplyGood(supplyGood),
    .overCurrent(overCurrent), .underVoltage(underVoltage), .offAck(offAck),
    .gate(gate), .ready(ready)
  );

  cardSeqPath u_path (
    .clk(clk), .rstN(rstN), .gate(gate),
    .hostRst(hostRst), .hostClk(hostClk), .hostIo(hostIo),
    .hostAux1(hostAux1), .hostAux2(hostAux2),
    .cardRst(cardRst), .cardClk(cardClk), .cardIo(cardIo),
    .cardAux1(cardAux1), .cardAux2(cardAux2), .supplyEn(supplyEn)
  );

endmodule

// File: tb/cardPowerSeq_tb.sv
module cardPowerSeq_tb;

  localparam int TR  = 10;
  localparam int TC  = 20;
  localparam int TI  = 30;
  localparam int TV  = 40;
  localparam int TK  = 300;
  localparam int SUM = TR + TC + TI + TV;

  // Output index: 0 rst,1 clk,2 io,3 aux1,4 aux2,5 supplyEn,6 ready
  typedef struct {
    int    cyc;
    int    idx;
    bit    val;
    string req;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdVccAN = 1'b1, cmdVccBN = 1'b1;
  logic hostRst = 1'b1, hostClk = 1'b1, hostIo = 1'b1, hostAux1 = 1'b1, hostAux2 = 1'b1;
  logic cardPresent = 1'b1, offN = 1'b1, supplyGood = 1'b1;
  logic overCurrent = 1'b0, underVoltage = 1'b0, offAck = 1'b0;
  logic cardRst, cardClk, cardIo, cardAux1, cardAux2, supplyEn, ready;
  logic [6:0] obs;

  int cyc = 0;
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  expItem_t scoreQ[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign obs = {ready, supplyEn, cardAux2, cardAux1, cardIo, cardClk, cardRst};

  cardPowerSeq #(.T_RST(TR), .T_CLK(TC), .T_IO(TI), .T_VCC(TV), .T_CHK(TK)) u_dut (
    .clk(clk), .rstN(rstN), .cmdVccAN(cmdVccAN), .cmdVccBN(cmdVccBN),
    .hostRst(hostRst), .hostClk(hostClk), .hostIo(hostIo),
    .hostAux1(hostAux1), .hostAux2(hostAux2),
    .cardPresent(cardPresent), .offN(offN), .supplyGood(supplyGood),
    .overCurrent(overCurrent), .underVoltage(underVoltage), .offAck(offAck),
    .cardRst(cardRst), .cardClk(cardClk), .cardIo(cardIo),
    .cardAux1(cardAux1), .cardAux2(cardAux2), .supplyEn(supplyEn), .ready(ready)
  );

  // Driver side: queue an expected value d edges from now
  task automatic expectAt(input int d, input int idx, input bit val, input string req);
    expItem_t it;
    it.cyc = cyc + d; it.idx = idx; it.val = val; it.req = req;
    scoreQ.push_back(it);
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compare queued items whose cycle has come
  initial begin
    forever begin
      @(negedge clk);
      #1;
      for (int i = scoreQ.size() - 1; i >= 0; i--) begin
        if (scoreQ[i].cyc == cyc) begin
          checks++;
          if (obs[scoreQ[i].idx] !== scoreQ[i].val) begin
            failures++;
            $display("FAIL %s cyc=%0d out%0d actual=%b expected=%b", scoreQ[i].req,
                     cyc, scoreQ[i].idx, obs[scoreQ[i].idx], scoreQ[i].val);
          end
          scoreQ.delete(i);
        end
      end
    end
  end

  task automatic finishRun();
    if (scoreQ.size() != 0) begin
      failures += scoreQ.size();
      $display("FAIL scoreboard %0d expected items never compared, actual=%0d expected=0",
               scoreQ.size(), scoreQ.size());
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      finishRun();
    end
  end

  initial begin
    waitCyc(3);
    rstN = 1'b1;
    for (int k = 0; k < 7; k++) expectAt(0, k, 1'b0, "R1");
    waitCyc(2);

    // Activation on command A, host lines high before ready
    cmdVccAN = 1'b0;
    expectAt(1, 5, 1'b1, "R2");
    expectAt(1, 6, 1'b0, "R3");
    expectAt(1, 1, 1'b0, "R3");
    expectAt(1, 0, 1'b0, "R3");
    expectAt(1, 3, 1'b0, "R3");
    expectAt(2, 6, 1'b1, "R4");
    expectAt(2, 1, 1'b1, "R4");
    expectAt(2, 4, 1'b1, "R4");
    waitCyc(3);
    hostClk = 1'b0; hostIo = 1'b0;
    expectAt(0, 1, 1'b0, "R4");
    expectAt(0, 2, 1'b0, "R4");
    expectAt(0, 0, 1'b1, "R4");
    waitCyc(1);
    hostClk = 1'b1; hostIo = 1'b1;
    expectAt(0, 1, 1'b1, "R4");
    waitCyc(2);

    // Host power-down: exact step edges, host lines held high
    cmdVccAN = 1'b1;
    expectAt(1, 6, 1'b0, "R6");
    expectAt(TR, 0, 1'b1, "R7");
    expectAt(TR + 1, 0, 1'b0, "R7");
    expectAt(TR + 1, 1, 1'b1, "R7");
    expectAt(TR + TC, 1, 1'b1, "R8");
    expectAt(TR + TC + 1, 1, 1'b0, "R8");
    expectAt(TR + TC + 1, 2, 1'b1, "R7");
    expectAt(TR + TC + TI, 3, 1'b1, "R7");
    expectAt(TR + TC + TI + 1, 2, 1'b0, "R7");
    expectAt(TR + TC + TI + 1, 3, 1'b0, "R7");
    expectAt(TR + TC + TI + 1, 4, 1'b0, "R7");
    expectAt(TR + TC + TI + 1, 5, 1'b1, "R7");
    expectAt(SUM, 5, 1'b1, "R7");
    expectAt(SUM + 1, 5, 1'b0, "R7");
    waitCyc(SUM + 3);

    // No card: start refused
    cardPresent = 1'b0;
    cmdVccBN = 1'b0;
    expectAt(1, 5, 1'b0, "R2");
    expectAt(3, 5, 1'b0, "R2");
    waitCyc(4);
    cmdVccBN = 1'b1; cardPresent = 1'b1;
    waitCyc(2);
    // offN low: start refused
    offN = 1'b0;
    cmdVccAN = 1'b0;
    expectAt(1, 5, 1'b0, "R2");
    waitCyc(3);
    cmdVccAN = 1'b1; offN = 1'b1;
    waitCyc(2);

    // Start on command B, then overcurrent
    cmdVccBN = 1'b0;
    expectAt(2, 6, 1'b1, "R2");
    waitCyc(3);
    overCurrent = 1'b1;
    expectAt(1, 6, 1'b0, "R6");
    expectAt(TR + 1, 0, 1'b0, "R6");
    expectAt(TR + TC + 1, 1, 1'b0, "R8");
    expectAt(SUM + 1, 5, 1'b0, "R6");
    waitCyc(SUM + 3);
    overCurrent = 1'b0;
    waitCyc(1);
    // Command B still low: a fall on A must not rearm
    cmdVccAN = 1'b0;
    expectAt(1, 5, 1'b0, "R9");
    expectAt(3, 5, 1'b0, "R9");
    waitCyc(4);
    cmdVccAN = 1'b1; cmdVccBN = 1'b1;
    waitCyc(2);
    cmdVccAN = 1'b0;
    expectAt(1, 5, 1'b1, "R9");
    expectAt(2, 6, 1'b1, "R9");
    waitCyc(3);

    // Undervoltage
    underVoltage = 1'b1;
    expectAt(1, 6, 1'b0, "R6");
    expectAt(SUM + 1, 5, 1'b0, "R6");
    waitCyc(SUM + 3);
    underVoltage = 1'b0; cmdVccAN = 1'b1;
    waitCyc(2);

    // Off acknowledge, single-cycle pulse
    cmdVccAN = 1'b0;
    expectAt(2, 6, 1'b1, "R4");
    waitCyc(3);
    offAck = 1'b1;
    expectAt(1, 6, 1'b0, "R6");
    waitCyc(1);
    offAck = 1'b0;
    expectAt(SUM, 5, 1'b0, "R6");
    waitCyc(SUM + 2);
    cmdVccAN = 1'b1;
    waitCyc(2);

    // Card withdrawn mid-session
    cmdVccAN = 1'b0;
    waitCyc(3);
    cardPresent = 1'b0;
    expectAt(1, 6, 1'b0, "R6");
    expectAt(TR + 1, 0, 1'b0, "R6");
    waitCyc(SUM + 3);
    cardPresent = 1'b1; cmdVccAN = 1'b1;
    waitCyc(2);

    // Checkpoint: supply never valid
    supplyGood = 1'b0;
    cmdVccAN = 1'b0;
    expectAt(1, 5, 1'b1, "R5");
    expectAt(2, 1, 1'b0, "R3");
    expectAt(TK, 6, 1'b0, "R5");
    expectAt(TK + TR + 1, 0, 1'b0, "R3");
    expectAt(TK + SUM, 5, 1'b1, "R5");
    expectAt(TK + SUM + 1, 5, 1'b0, "R5");
    waitCyc(TK + SUM + 3);
    cmdVccAN = 1'b1;
    waitCyc(2);

    // Checkpoint: supply valid late but in time
    cmdVccAN = 1'b0;
    waitCyc(50);
    supplyGood = 1'b1;
    expectAt(1, 6, 1'b1, "R5");
    expectAt(TK, 6, 1'b1, "R5");
    expectAt(TK, 5, 1'b1, "R5");
    waitCyc(TK + 2);
    cmdVccAN = 1'b1;
    waitCyc(SUM + 5);

    finished = 1'b1;
    finishRun();
  end

endmodule